// File: doc/BRIEF.md
# Late-Sampling Serial Flash Read Master

This block reads from an external serial flash. It builds the flash clock, an active-low chip select and a four-bit data bus from a faster system clock. A request carries an opcode byte, a 24-bit address, a count of dummy clocks, a lane-mode flag and a byte count. The block then runs one chip-select window: the opcode and address go out, the output drivers are released for the dummy clocks, and the requested number of bytes is read in. The bytes leave on a valid/ready stream. A one-cycle done pulse marks the end of the transfer.

The clock idles low and outgoing bits follow mode-0 conventions. They are placed on the lines when chip select falls and after each falling clock edge. The return path differs from plain mode 0. Each incoming bit is sampled on the falling edge that ends its clock cycle, which is the same edge that launches the next outgoing bit. The flash must therefore hold each bit for a whole clock cycle. Chip select is released only after the last bit has been taken.

If the stream consumer holds off while a byte is pending, the flash clock is parked low until that byte is taken. No read data is ever dropped.

Top module: `qspi_late_master`

## Requirements
- R1: The flash clock `sclk` is low whenever `cs_n` is high, and it is low when `cs_n` falls and when `cs_n` rises.
- R2: `dio_out` and `dio_oe` change only at the edge where `cs_n` falls or at a falling edge of `sclk`. While `sclk` is high they hold steady.
- R3: Each read bit is sampled at the falling `sclk` edge that ends its clock cycle. Bytes come out on `rd_data` in the order they were read, and each byte is assembled with its first-received bit as bit 7.
- R4: A transfer contains exactly header + dummy + data `sclk` cycles. `cs_n` rises half an `sclk` period after the final falling edge, never before it.
- R5: In single-lane mode (`req_quad`=0), the block drives only `dio_out[0]` (`dio_oe`=4'b0001) and reads from `dio_in[1]`. In quad mode (`req_quad`=1), it drives all four lines (`dio_oe`=4'b1111) and reads all four. A nibble moves per clock, high nibble first, and `dio_out[3]` carries the most significant bit of the nibble.
- R6: The header is `{req_cmd, req_addr}`, 32 bits sent most significant bit first. That is 32 clocks in single-lane mode and 8 clocks in quad mode.
- R7: `req_dummy` clocks follow the header with `dio_oe`=0. The data clocks also run with `dio_oe`=0. A dummy count of 0 leaves no gap.
- R8: `req_ready` is high only while no transfer is active, and a request is taken when `req_valid` and `req_ready` are both high. `done` is high for one system clock, exactly one clock after `cs_n` rises.
- R9: One `sclk` period lasts `CLK_DIV` system clocks, and the high phase is `CLK_DIV/2` clocks.
- R10: While `rd_valid` is high and `rd_ready` is low, `rd_data` holds steady and `sclk` is parked low. No byte completes while the previous one is still waiting.
- R11: A byte count of 0 gives a transfer with no data clocks, and no bytes are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_cmd | input | 8 | Opcode byte |
| req_addr | input | 24 | Flash address |
| req_dummy | input | DUM_W | Dummy clock count |
| req_quad | input | 1 | 1 = four lanes, 0 = single lane |
| req_len | input | LEN_W | Number of bytes to read |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer accepts the byte |
| rd_data | output | 8 | Read byte |
| done | output | 1 | One-cycle end-of-transfer pulse |
| sclk | output | 1 | Flash clock |
| cs_n | output | 1 | Active-low chip select |
| dio_out | output | 4 | Data lines, outgoing values |
| dio_oe | output | 4 | Per-line output enable |
| dio_in | input | 4 | Data lines, incoming values |

## Verification
Two events can fall on a single falling edge of `sclk`. That edge completes a read byte, and the previous byte may still be waiting on the stream while it does. To provoke this, the bench runs quad-mode reads, where a byte takes only two clocks, and keeps the consumer ready for just one cycle in nineteen. It judges the result with the scoreboard: the bytes must come out complete and in order, `rd_data` must stay steady while stalled, and the flash clock's high phase must never be stretched. The final capture and the chip-select release are checked as well: every transfer must contain the exact number of clock cycles, with `cs_n` rising only after `sclk` is back low.

// File: rtl/qlm_pkg.sv
package qlm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HDR,
    PH_DUMMY,
    PH_DATA,
    PH_TAIL
  } phase_t;

  // clocks needed for the 32-bit opcode+address header
  function automatic logic [5:0] f_hdr_periods(input logic quad);
    return quad ? 6'd8 : 6'd32;
  endfunction

  // clocks needed for one read byte
  function automatic logic [5:0] f_byte_periods(input logic quad);
    return quad ? 6'd2 : 6'd8;
  endfunction

  function automatic logic [3:0] f_lane_oe(input logic quad);
    return quad ? 4'hF : 4'h1;
  endfunction

  function automatic logic [3:0] f_tx_lanes(input logic [31:0] sr, input logic quad);
    return quad ? sr[31:28] : {3'b000, sr[31]};
  endfunction

  function automatic logic [31:0] f_tx_shift(input logic [31:0] sr, input logic quad);
    return quad ? {sr[27:0], 4'h0} : {sr[30:0], 1'b0};
  endfunction

  function automatic logic [7:0] f_rx_next(input logic [7:0] sr, input logic [3:0] din,
                                           input logic quad);
    return quad ? {sr[3:0], din} : {sr[6:0], din[1]};
  endfunction

endpackage

// File: rtl/qlm_clkgen.sv
module qlm_clkgen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic park,
  input  logic stall,
  output logic sclk,
  output logic fall_ev,
  output logic half_ev
);
  localparam int HALF  = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CNT_W-1:0] cnt;
  logic             step;
  logic             at_end;
  logic             rise_ev;

  // the clock may only be frozen in its low phase
  assign step    = !(stall && !sclk);
  assign at_end  = (cnt == CNT_W'(HALF - 1));
  assign half_ev = run && step && at_end;
  assign rise_ev = half_ev && !sclk && !park;
  assign fall_ev = half_ev && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (step) begin
      if (at_end) begin
        cnt <= '0;
        if (rise_ev)      sclk <= 1'b1;
        else if (fall_ev) sclk <= 1'b0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/qlm_seq.sv
module qlm_seq
  import qlm_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int DUM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_quad,
  input  logic [DUM_W-1:0] req_dummy,
  input  logic [LEN_W-1:0] req_len,
  input  logic             fall_ev,
  input  logic             half_ev,
  input  logic             rd_pending,
  output logic             req_ready,
  output logic             accept,
  output logic             cs_n,
  output logic             done,
  output logic             quad,
  output logic             run,
  output logic             park,
  output logic             stall,
  output logic             tx_shift,
  output logic             capture,
  output logic             byte_done,
  output logic [3:0]       dio_oe
);
  localparam int LEFT_W = (DUM_W > 6) ? DUM_W : 6;

  phase_t             phase;
  logic [LEFT_W-1:0]  left;
  logic [LEN_W-1:0]   bytes_left;
  logic [DUM_W-1:0]   dummy_q;
  logic               cs_n_d;
  logic               last_period;
  logic [LEFT_W-1:0]  byte_periods;

  assign req_ready    = (phase == PH_IDLE);
  assign accept       = req_valid && req_ready;
  assign cs_n         = (phase == PH_IDLE);
  assign run          = !cs_n;
  assign park         = (phase == PH_TAIL);
  assign stall        = rd_pending && (phase inside {PH_HDR, PH_DUMMY, PH_DATA});
  assign last_period  = (left == LEFT_W'(1));
  assign tx_shift     = fall_ev && (phase == PH_HDR);
  assign capture      = fall_ev && (phase == PH_DATA);
  assign byte_done    = capture && last_period;
  assign dio_oe       = (phase == PH_HDR) ? f_lane_oe(quad) : 4'h0;
  assign byte_periods = LEFT_W'(f_byte_periods(quad));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      left       <= '0;
      bytes_left <= '0;
      dummy_q    <= '0;
      quad       <= 1'b0;
    end else if (accept) begin
      phase      <= PH_HDR;
      left       <= LEFT_W'(f_hdr_periods(req_quad));
      bytes_left <= req_len;
      dummy_q    <= req_dummy;
      quad       <= req_quad;
    end else begin
      case (phase)
        PH_HDR: if (fall_ev) begin
          if (!last_period) begin
            left <= left - LEFT_W'(1);
          end else if (dummy_q != '0) begin
            phase <= PH_DUMMY;
            left  <= LEFT_W'(dummy_q);
          end else if (bytes_left != '0) begin
            phase <= PH_DATA;
            left  <= byte_periods;
          end else begin
            phase <= PH_TAIL;
          end
        end
        PH_DUMMY: if (fall_ev) begin
          if (!last_period) begin
            left <= left - LEFT_W'(1);
          end else if (bytes_left != '0) begin
            phase <= PH_DATA;
            left  <= byte_periods;
          end else begin
            phase <= PH_TAIL;
          end
        end
        PH_DATA: if (fall_ev) begin
          if (!last_period) begin
            left <= left - LEFT_W'(1);
          end else if (bytes_left == LEN_W'(1)) begin
            phase <= PH_TAIL;
          end else begin
            bytes_left <= bytes_left - LEN_W'(1);
            left       <= byte_periods;
          end
        end
        PH_TAIL: if (half_ev) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_d <= 1'b1;
      done   <= 1'b0;
    end else begin
      cs_n_d <= cs_n;
      done   <= cs_n && !cs_n_d;
    end
  end

endmodule

// File: rtl/qlm_datapath.sv
module qlm_datapath
  import qlm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [7:0]  cmd,
  input  logic [23:0] addr,
  input  logic        quad,
  input  logic        tx_shift,
  input  logic        capture,
  input  logic        byte_done,
  input  logic [3:0]  oe,
  input  logic [3:0]  dio_in,
  input  logic        rd_ready,
  output logic [3:0]  dio_out,
  output logic [7:0]  rd_data,
  output logic        rd_valid
);
  logic [31:0] tx_sr;
  logic [7:0]  rx_sr;
  logic [7:0]  rx_next;

  assign dio_out = f_tx_lanes(tx_sr, quad) & oe;
  assign rx_next = f_rx_next(rx_sr, dio_in, quad);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
    end else if (load) begin
      tx_sr <= {cmd, addr};
    end else if (tx_shift) begin
      tx_sr <= f_tx_shift(tx_sr, quad);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr    <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (capture) rx_sr <= rx_next;
      if (byte_done) begin
        rd_data  <= rx_next;
        rd_valid <= 1'b1;
      end else if (rd_ready) begin
        rd_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/qspi_late_master.sv
module qspi_late_master #(
  parameter int CLK_DIV = 4,
  parameter int LEN_W   = 8,
  parameter int DUM_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [7:0]       req_cmd,
  input  logic [23:0]      req_addr,
  input  logic [DUM_W-1:0] req_dummy,
  input  logic             req_quad,
  input  logic [LEN_W-1:0] req_len,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             sclk,
  output logic             cs_n,
  output logic [3:0]       dio_out,
  output logic [3:0]       dio_oe,
  input  logic [3:0]       dio_in
);
  // named internal events, also observed by the bound checker
  logic accept, quad, run, park, stall;
  logic fall_ev, half_ev;
  logic tx_shift, capture, byte_done;
  logic rd_pending;

  assign rd_pending = rd_valid && !rd_ready;

  qlm_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .park    (park),
    .stall   (stall),
    .sclk    (sclk),
    .fall_ev (fall_ev),
    .half_ev (half_ev)
  );

  qlm_seq #(.LEN_W(LEN_W), .DUM_W(DUM_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_quad   (req_quad),
    .req_dummy  (req_dummy),
    .req_len    (req_len),
    .fall_ev    (fall_ev),
    .half_ev    (half_ev),
    .rd_pending (rd_pending),
    .req_ready  (req_ready),
    .accept     (accept),
    .cs_n       (cs_n),
    .done       (done),
    .quad       (quad),
    .run        (run),
    .park       (park),
    .stall      (stall),
    .tx_shift   (tx_shift),
    .capture    (capture),
    .byte_done  (byte_done),
    .dio_oe     (dio_oe)
  );

  qlm_datapath u_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .cmd       (req_cmd),
    .addr      (req_addr),
    .quad      (quad),
    .tx_shift  (tx_shift),
    .capture   (capture),
    .byte_done (byte_done),
    .oe        (dio_oe),
    .dio_in    (dio_in),
    .rd_ready  (rd_ready),
    .dio_out   (dio_out),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

endmodule

// File: rtl/qlm_checker.sv
module qlm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk,
  input logic       cs_n,
  input logic [3:0] dio_out,
  input logic [3:0] dio_oe,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       req_ready,
  input logic       done,
  input logic       byte_done
);

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R1

  AST_TX_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> ($stable(dio_out) && $stable(dio_oe))); // R2

  AST_CAPTURE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> (sclk && !cs_n)); // R3

  AST_CS_AFTER_LAST_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (!sclk && !$past(sclk))); // R4

  AST_LANE_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (dio_oe != 4'h0) |-> (!cs_n && (dio_oe == 4'h1 || dio_oe == 4'hF))); // R5

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !req_ready); // R8

  AST_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> done); // R8

  AST_DONE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n); // R8

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> (!rd_valid || rd_ready)); // R10

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R10

endmodule

bind qspi_late_master qlm_checker u_qlm_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .sclk      (sclk),
  .cs_n      (cs_n),
  .dio_out   (dio_out),
  .dio_oe    (dio_oe),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data),
  .req_ready (req_ready),
  .done      (done),
  .byte_done (byte_done)
);

// File: tb/qspi_late_master_bench.sv
`timescale 1ns/1ps
module qspi_late_master_bench;
  localparam int CLK_DIV = 4;
  localparam int HALF    = CLK_DIV / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_cmd = '0;
  logic [23:0] req_addr = '0;
  logic [4:0]  req_dummy = '0;
  logic        req_quad = 1'b0;
  logic [7:0]  req_len = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b1;
  logic [7:0]  rd_data;
  logic        done;
  logic        sclk;
  logic        cs_n;
  logic [3:0]  dio_out;
  logic [3:0]  dio_oe;
  logic [3:0]  dio_in = 4'h0;

  always #5 clk = ~clk;

  qspi_late_master #(.CLK_DIV(CLK_DIV)) u_qspi_late_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_dummy(req_dummy),
    .req_quad(req_quad), .req_len(req_len), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .done(done), .sclk(sclk),
    .cs_n(cs_n), .dio_out(dio_out), .dio_oe(dio_oe), .dio_in(dio_in)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat_byte(input logic [23:0] a, input int j);
    return a[7:0] ^ a[15:8] ^ 8'(j * 59 + 17);
  endfunction

  // current transfer, as seen by the flash model and scoreboard
  logic [7:0]  cur_cmd;
  logic [23:0] cur_addr;
  int          cur_dummy, cur_len;
  bit          cur_quad, in_xfer, stall_mode;
  logic [7:0]  exp_q [$];

  // flash model
  int          rise_cnt, fall_cnt;
  logic [31:0] hdr_rx;
  bit          lane_bad, rel_bad, hi_bad;
  time         t_rise;

  always @(negedge cs_n) begin
    rise_cnt = 0; fall_cnt = 0; hdr_rx = '0;
    lane_bad = 0; rel_bad = 0; hi_bad = 0;
  end

  always @(posedge sclk) if (!cs_n) begin
    int hp;
    hp = cur_quad ? 8 : 32;
    t_rise = $time;
    if (rise_cnt < hp) begin
      if (cur_quad) begin
        if (dio_oe !== 4'hF) lane_bad = 1;
        hdr_rx = {hdr_rx[27:0], dio_out};
      end else begin
        if (dio_oe !== 4'h1) lane_bad = 1;
        hdr_rx = {hdr_rx[30:0], dio_out[0]};
      end
    end else if (dio_oe !== 4'h0) begin
      rel_bad = 1;
    end
    rise_cnt++;
  end

  // each read bit is presented just after a falling edge and held a full cycle
  always @(negedge sclk) if (!cs_n) begin
    int hp, bpb, p0, d;
    logic [7:0] b;
    logic bt;
    if ($time - t_rise != HALF * 10) hi_bad = 1;
    hp  = cur_quad ? 8 : 32;
    bpb = cur_quad ? 2 : 8;
    fall_cnt++;
    p0 = hp + cur_dummy;
    if (fall_cnt >= p0 && fall_cnt - p0 < cur_len * bpb) begin
      d = fall_cnt - p0;
      b = pat_byte(cur_addr, d / bpb);
      if (cur_quad) dio_in = (d % 2 == 0) ? b[7:4] : b[3:0];
      else begin
        bt = b[7 - (d % 8)];
        dio_in = {~bt, ~bt, bt, ~bt};
      end
    end else begin
      dio_in = 4'h0;
    end
  end

  always @(posedge cs_n) if (in_xfer) begin
    int exp_n;
    exp_n = (cur_quad ? 8 : 32) + cur_dummy + cur_len * (cur_quad ? 2 : 8);
    chk(rise_cnt == exp_n, (cur_len == 0) ? "R11" : "R4", "sclk cycles in window",
        64'(rise_cnt), 64'(exp_n));
    chk(hdr_rx == {cur_cmd, cur_addr}, "R6", "header seen by flash", hdr_rx,
        {cur_cmd, cur_addr});
    chk(!lane_bad, "R5", "header lane enables", 64'(lane_bad), 0);
    chk(!rel_bad, "R7", "drivers released after header", 64'(rel_bad), 0);
    chk(!hi_bad, "R9", "sclk high phase length", 64'(hi_bad), 0);
    chk(sclk == 1'b0, "R1", "sclk low at cs release", 64'(sclk), 0);
  end

  // monitor: done timing, consumer pacing, stall hold, scoreboard
  bit         cs_prev = 1'b1, done_due = 0, prev_pending = 0, hold_bad = 0;
  logic [7:0] prev_data;
  int         cyc = 0, stall_cycles = 0;

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (done_due) begin
      chk(done === 1'b1, "R8", "done one clock after cs rise", 64'(done), 1);
      done_due = 0;
    end else if (done === 1'b1) begin
      chk(0, "R8", "unexpected done", 64'(done), 0);
    end
    if (cs_n && !cs_prev) begin
      chk(done === 1'b0, "R8", "done not with cs rise", 64'(done), 0);
      done_due = 1;
    end
    cs_prev = cs_n;

    if (prev_pending) begin
      stall_cycles++;
      if (!(rd_valid && rd_data == prev_data)) hold_bad = 1;
    end
    rd_ready = stall_mode ? (cyc % 19 == 0) : 1'b1;
    prev_pending = rd_valid && !rd_ready;
    prev_data = rd_data;

    if (rd_valid && rd_ready) begin
      if (exp_q.size() == 0) chk(0, "R3", "byte with none expected", 64'(rd_data), 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rd_data === e, cur_quad ? "R5" : "R3", "read byte", 64'(rd_data), 64'(e));
      end
    end
  end

  task automatic do_xfer(input logic [7:0] cmd, input logic [23:0] addr,
                         input int dummy, input bit quad, input int len, input bit stall);
    int n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_cmd = cmd; cur_addr = addr; cur_dummy = dummy; cur_quad = quad; cur_len = len;
    stall_mode = stall;
    for (int j = 0; j < len; j++) exp_q.push_back(pat_byte(addr, j));
    in_xfer = 1;
    req_cmd = cmd; req_addr = addr; req_dummy = 5'(dummy); req_quad = quad;
    req_len = 8'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready && !cs_n, "R8", "busy after accept", {62'd0, req_ready, cs_n}, 0);
    n = 0;
    while (done !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
    chk(done === 1'b1, "R8", "transfer completes", 64'(done), 1);
    n = 0;
    while (exp_q.size() != 0 && n < 200) begin @(negedge clk); n++; end
    chk(exp_q.size() == 0, "R3", "all bytes delivered", 64'(exp_q.size()), 0);
    stall_mode = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0, "R1", "reset idle lines", {62'd0, cs_n, sclk}, 2);
    chk(dio_oe === 4'h0, "R5", "no drive after reset", 64'(dio_oe), 0);
    chk(req_ready === 1'b1 && rd_valid === 1'b0 && done === 1'b0, "R8",
        "reset handshake state", {61'd0, req_ready, rd_valid, done}, 4);

    do_xfer(8'h03, 24'h123456, 0, 1'b0, 4, 1'b0);   // single, no dummy
    do_xfer(8'hEB, 24'hABCDEF, 6, 1'b1, 5, 1'b0);   // quad with dummy
    do_xfer(8'h0B, 24'h00F00F, 8, 1'b0, 3, 1'b1);   // single, stalled consumer
    do_xfer(8'h6B, 24'h55AA33, 0, 1'b1, 0, 1'b0);   // R11: no data clocks
    do_xfer(8'hBB, 24'h808182, 4, 1'b1, 6, 1'b1);   // R10: quad under backpressure
    do_xfer(8'hFF, 24'hFFFFFF, 1, 1'b0, 1, 1'b0);   // R7: one dummy clock

    chk(!hold_bad, "R10", "data held while stalled", 64'(hold_bad), 0);
    chk(stall_cycles > 0, "R10", "backpressure exercised", 64'(stall_cycles), 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule